// File: doc/BRIEF.md
# Capture/Compare/PWM Channel

This block is one timer-driven channel that works in one of three mode families, picked by a 4-bit mode field in an 8-bit control register. In capture mode it copies a free-running 16-bit timer into a readable 16-bit value register when the pin input shows a selected edge. The edge can be every falling edge, every rising edge, or every 4th or 16th rising edge. In compare mode it watches for the timer to equal the 16-bit value register. On a match it can drive the pin high, drive it low, only raise the interrupt flag, or raise the flag and pulse a timer-reset strobe and a converter-start strobe.

In PWM mode the same value register's low byte holds the upper eight bits of a 10-bit duty. Control bits 5:4 hold the two low bits. The duty is compared against a 10-bit count made from the 8-bit period timer and two fractional bits. Software reaches the block through a small synchronous register port. The timers, the converter and the prescaler clock all sit outside the block.

Top module: `ccp_unit`

## Requirements
- R1: After reset every register reads 0, pin_out, irq_flag and both strobes are low. Control bits 7:6 always read 0 (address 0 = control, 1 = value low, 2 = value high, 3 = period, 4 = flag in bit 0; reads return one cycle after the address).
- R2: A mode field of 0000, or any value 0001 to 0011, disables the channel. pin_out is forced low, no edge or match sets the flag, and the edge counter, match history and active duty return to their reset values.
- R3: Mode 0100 captures on each falling edge and mode 0101 on each rising edge of the pin. The timer value three clocks after the pin change is copied to the value registers and the flag is set. An edge of the other polarity does nothing.
- R4: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th. Any write to the control register clears the edge counter.
- R5: Mode 1000 puts the pin low one cycle after the control write. The pin goes high on the cycle after the timer first equals the value register, and the flag is set.
- R6: Mode 1001 puts the pin high one cycle after the control write. The pin goes low on a match, and the flag is set.
- R7: Mode 1010 sets the flag on a match and leaves the pin low.
- R8: Mode 1011 sets the flag on a match, leaves the pin low, and pulses tmr_reset_stb for exactly one cycle. adc_start_stb pulses with it when the ADC_TRIG_EN parameter is 1.
- R9: Writing the flag register loads bit 0 into the flag, so writing 0 clears it. A capture or match event in the same cycle wins over the write.
- R10: Any mode of the form 11xx is PWM. The duty is {value low byte, control bits 5:4} and the count is timer_val[9:0]. The duty is reloaded when the count equals {period, 2'b11}. Per period of 4*(period+1) counts, the pin is high for min(duty, 4*(period+1)) counts.
- R11: A duty of 0 gives a constant low pin. A duty at or above 4*(period+1) gives a constant high pin.
- R12: Outside PWM mode, control bits 5:4 have no effect on the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Registered read data |
| timer_val | input | 16 | Free-running timer; bits 9:0 serve as the PWM count |
| pin_in | input | 1 | Asynchronous capture input |
| pin_out | output | 1 | Compare / PWM output |
| irq_flag | output | 1 | Interrupt flag |
| tmr_reset_stb | output | 1 | One-cycle timer-reset request |
| adc_start_stb | output | 1 | One-cycle converter-start request |

## Verification
Capture is driven with isolated pulses while the timer is held at a distinct value for each pulse. This separates the falling-edge mode from the rising-edge mode, and shows that the flag stays low through 3 and 15 rising edges and rises exactly on the 4th and 16th. Rewriting the control register in the middle of a count shows that the counter is cleared rather than carried over. Compare is run in all four actions against the same match value, so each action's effect on the pin, the flag and the strobes can be told apart. PWM is measured over a full period at duties of 0, a midpoint with a nonzero fraction, the exact period length and above it.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam int ADDR_W   = 3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_VLO  = 3'd1;
  localparam logic [ADDR_W-1:0] A_VHI  = 3'd2;
  localparam logic [ADDR_W-1:0] A_PER  = 3'd3;
  localparam logic [ADDR_W-1:0] A_FLG  = 3'd4;

  typedef enum logic [1:0] {
    FAM_OFF = 2'b00,
    FAM_CAP = 2'b01,
    FAM_CMP = 2'b10,
    FAM_PWM = 2'b11
  } fam_e;

  // compare actions (mode bits 1:0 in the compare family)
  localparam logic [1:0] ACT_SET  = 2'b00;
  localparam logic [1:0] ACT_CLR  = 2'b01;
  localparam logic [1:0] ACT_IRQ  = 2'b10;
  localparam logic [1:0] ACT_EVT  = 2'b11;

  function automatic fam_e mode_family(input logic [3:0] m);
    return fam_e'(m[3:2]);
  endfunction
endpackage

// File: rtl/ccp_regs.sv
module ccp_regs
  import ccp_pkg::*;
#(
  parameter int REG_W = 8,
  parameter int TMR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic              cap_fire,
  input  logic [TMR_W-1:0]  cap_value,
  input  logic              evt_set,
  output logic [REG_W-3:0]  ctrl_q,
  output logic [TMR_W-1:0]  val_q,
  output logic [REG_W-1:0]  period_q,
  output logic              flag_q,
  output logic              ctrl_wr
);
  localparam int CTRL_W = REG_W - 2;

  logic wr_lo, wr_hi, wr_per, wr_flg;

  always_comb begin
    ctrl_wr = wr_en && (wr_addr == A_CTRL);
    wr_lo   = wr_en && (wr_addr == A_VLO);
    wr_hi   = wr_en && (wr_addr == A_VHI);
    wr_per  = wr_en && (wr_addr == A_PER);
    wr_flg  = wr_en && (wr_addr == A_FLG);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      val_q    <= '0;
      period_q <= '0;
      flag_q   <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= wr_data[CTRL_W-1:0];
      if (wr_per)  period_q <= wr_data;
      if (cap_fire) begin
        val_q <= cap_value;
      end else begin
        if (wr_lo) val_q[REG_W-1:0] <= wr_data;
        if (wr_hi) val_q[TMR_W-1:REG_W] <= wr_data;
      end
      if (evt_set)     flag_q <= 1'b1;
      else if (wr_flg) flag_q <= wr_data[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        A_CTRL:  rd_data <= {2'b00, ctrl_q};
        A_VLO:   rd_data <= val_q[REG_W-1:0];
        A_VHI:   rd_data <= val_q[TMR_W-1:REG_W];
        A_PER:   rd_data <= period_q;
        A_FLG:   rd_data <= {{(REG_W-1){1'b0}}, flag_q};
        default: rd_data <= '0;
      endcase
    end
  end

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    evt_set |=> flag_q);
endmodule

// File: rtl/ccp_capture.sv
module ccp_capture #(
  parameter int PRE_A = 4,
  parameter int PRE_B = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cap_en,
  input  logic [1:0] sub,
  input  logic       ctrl_wr,
  input  logic       pin_in,
  output logic       cap_fire
);
  localparam int CNT_W = $clog2(PRE_B);
  localparam int NEED_W = CNT_W + 1;

  logic s1, s2, prev;
  logic rise, fall, edge_hit;
  logic [CNT_W-1:0]  cnt;
  logic [NEED_W-1:0] need;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0; s2 <= 1'b0; prev <= 1'b0;
    end else begin
      s1 <= pin_in; s2 <= s1; prev <= s2;
    end
  end

  always_comb begin
    rise = s2 && !prev;
    fall = !s2 && prev;
    edge_hit = (sub == 2'b00) ? fall : rise;
    case (sub)
      2'b10:   need = NEED_W'(PRE_A);
      2'b11:   need = NEED_W'(PRE_B);
      default: need = NEED_W'(1);
    endcase
    cap_fire = cap_en && edge_hit && ({1'b0, cnt} == need - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst || !cap_en || ctrl_wr) begin
      cnt <= '0;
    end else if (edge_hit) begin
      cnt <= cap_fire ? '0 : cnt + 1'b1;
    end
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cap_en |-> ({1'b0, cnt} < need));
  // R3
  fire_edge_chk: assert property (@(posedge clk) disable iff (rst)
    cap_fire |-> (s2 != prev));
endmodule

// File: rtl/ccp_compare.sv
module ccp_compare
  import ccp_pkg::*;
#(
  parameter int TMR_W = 16,
  parameter bit ADC_TRIG_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_en,
  input  logic [1:0]       act,
  input  logic             ctrl_wr,
  input  logic [TMR_W-1:0] timer_val,
  input  logic [TMR_W-1:0] cmp_val,
  output logic             cmp_pin,
  output logic             cmp_hit,
  output logic             tmr_rst_stb,
  output logic             adc_stb
);
  logic match, match_q, cfg_d;

  always_comb begin
    match   = (timer_val == cmp_val);
    cmp_hit = cmp_en && match && !match_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q     <= 1'b0;
      cfg_d       <= 1'b0;
      cmp_pin     <= 1'b0;
      tmr_rst_stb <= 1'b0;
      adc_stb     <= 1'b0;
    end else begin
      match_q     <= cmp_en && match;
      cfg_d       <= ctrl_wr;
      tmr_rst_stb <= cmp_hit && (act == ACT_EVT);
      adc_stb     <= ADC_TRIG_EN && cmp_hit && (act == ACT_EVT);
      if (!cmp_en)                       cmp_pin <= 1'b0;
      else if (cfg_d)                    cmp_pin <= (act == ACT_CLR);
      else if (cmp_hit && act == ACT_SET) cmp_pin <= 1'b1;
      else if (cmp_hit && act == ACT_CLR) cmp_pin <= 1'b0;
    end
  end

  // R5
  set_on_match_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_hit && act == ACT_SET && !cfg_d) |=> cmp_pin);
  // R6
  clr_on_match_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_hit && act == ACT_CLR && !cfg_d) |=> !cmp_pin);
  // R7
  pin_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_en && act[1] && !cfg_d) |=> $stable(cmp_pin));
  // R8
  strobe_src_chk: assert property (@(posedge clk) disable iff (rst)
    tmr_rst_stb |-> ($past(act) == ACT_EVT && $past(cmp_en)));
endmodule

// File: rtl/ccp_pwm.sv
module ccp_pwm #(
  parameter int REG_W = 8,
  parameter int FRAC_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    pwm_en,
  input  logic [REG_W-1:0]        period,
  input  logic [REG_W+FRAC_W-1:0] duty_buf,
  input  logic [REG_W+FRAC_W-1:0] cnt,
  output logic                    pwm_out
);
  localparam int PW = REG_W + FRAC_W;

  logic [PW-1:0] duty_act;
  logic          period_end;

  assign period_end = (cnt == {period, {FRAC_W{1'b1}}});

  always_ff @(posedge clk) begin
    if (rst || !pwm_en) begin
      duty_act <= '0;
      pwm_out  <= 1'b0;
    end else begin
      if (period_end) duty_act <= duty_buf;
      pwm_out <= (cnt < duty_act);
    end
  end

  // R11
  duty_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (pwm_en && duty_act == '0) |=> !pwm_out);
  // R2
  pwm_off_chk: assert property (@(posedge clk) disable iff (rst)
    !pwm_en |=> (!pwm_out && duty_act == '0));
endmodule

// File: rtl/ccp_unit.sv
module ccp_unit
  import ccp_pkg::*;
#(
  parameter int REG_W = 8,
  parameter int PWM_FRAC = 2,
  parameter int PRE_A = 4,
  parameter int PRE_B = 16,
  parameter bit ADC_TRIG_EN = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [REG_W-1:0]     wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [REG_W-1:0]     rd_data,
  input  logic [2*REG_W-1:0]   timer_val,
  input  logic                 pin_in,
  output logic                 pin_out,
  output logic                 irq_flag,
  output logic                 tmr_reset_stb,
  output logic                 adc_start_stb
);
  localparam int TMR_W = 2 * REG_W;
  localparam int PW    = REG_W + PWM_FRAC;

  logic [REG_W-3:0] ctrl_q;
  logic [TMR_W-1:0] val_q;
  logic [REG_W-1:0] period_q;
  logic             ctrl_wr, cap_fire, cmp_hit, cmp_pin, pwm_out;
  logic             cap_en, cmp_en, pwm_en;
  fam_e             fam;

  always_comb begin
    fam    = mode_family(ctrl_q[3:0]);
    cap_en = (fam == FAM_CAP);
    cmp_en = (fam == FAM_CMP);
    pwm_en = (fam == FAM_PWM);
    pin_out = pwm_en ? pwm_out : (cmp_en ? cmp_pin : 1'b0);
  end

  ccp_regs #(.REG_W(REG_W), .TMR_W(TMR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cap_fire(cap_fire),
    .cap_value(timer_val), .evt_set(cap_fire || cmp_hit), .ctrl_q(ctrl_q),
    .val_q(val_q), .period_q(period_q), .flag_q(irq_flag), .ctrl_wr(ctrl_wr)
  );

  ccp_capture #(.PRE_A(PRE_A), .PRE_B(PRE_B)) u_cap (
    .clk(clk), .rst(rst), .cap_en(cap_en), .sub(ctrl_q[1:0]),
    .ctrl_wr(ctrl_wr), .pin_in(pin_in), .cap_fire(cap_fire)
  );

  ccp_compare #(.TMR_W(TMR_W), .ADC_TRIG_EN(ADC_TRIG_EN)) u_cmp (
    .clk(clk), .rst(rst), .cmp_en(cmp_en), .act(ctrl_q[1:0]),
    .ctrl_wr(ctrl_wr), .timer_val(timer_val), .cmp_val(val_q),
    .cmp_pin(cmp_pin), .cmp_hit(cmp_hit), .tmr_rst_stb(tmr_reset_stb),
    .adc_stb(adc_start_stb)
  );

  ccp_pwm #(.REG_W(REG_W), .FRAC_W(PWM_FRAC)) u_pwm (
    .clk(clk), .rst(rst), .pwm_en(pwm_en), .period(period_q),
    .duty_buf({val_q[REG_W-1:0], ctrl_q[5:4]}), .cnt(timer_val[PW-1:0]),
    .pwm_out(pwm_out)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!irq_flag && !pin_out && !tmr_reset_stb && !adc_start_stb));
endmodule

// File: tb/ccp_unit_bench.sv
module ccp_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic [15:0] timer_val = '0;
  logic        pin_in = 1'b0;
  logic        pin_out, irq_flag, tmr_reset_stb, adc_start_stb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ccp_unit u_ccp_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .timer_val(timer_val),
    .pin_in(pin_in), .pin_out(pin_out), .irq_flag(irq_flag),
    .tmr_reset_stb(tmr_reset_stb), .adc_start_stb(adc_start_stb)
  );

  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    step();
    d = rd_data;
  endtask

  task automatic pulse();
    pin_in = 1'b1; step(4);
    pin_in = 1'b0; step(4);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      chk("R1 reset register", d, 0);
    end
    chk("R1 reset outputs", {pin_out, irq_flag, tmr_reset_stb, adc_start_stb}, 0);
    wr(3'd0, 8'hFA);
    rd(3'd0, d);
    chk("R1 ctrl 7:6 read zero", d, 8'h3A);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_capture_edges();
    logic [7:0] lo, hi;
    wr(3'd0, 8'h05); wr(3'd4, 8'h00);
    timer_val = 16'hA5C3;
    pin_in = 1'b1; step(3);
    chk("R3 rising capture flag", irq_flag, 1);
    step(2); pin_in = 1'b0; step(4);
    rd(3'd1, lo); rd(3'd2, hi);
    chk("R3 rising capture value", {hi, lo}, 16'hA5C3);
    wr(3'd4, 8'h00);
    chk("R9 flag cleared by write", irq_flag, 0);
    wr(3'd0, 8'h04);
    timer_val = 16'h1111;
    pin_in = 1'b1; step(5);
    chk("R3 falling mode ignores rise", irq_flag, 0);
    timer_val = 16'h2222;
    pin_in = 1'b0; step(5);
    rd(3'd1, lo); rd(3'd2, hi);
    chk("R3 falling capture flag", irq_flag, 1);
    chk("R3 falling capture value", {hi, lo}, 16'h2222);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_capture_prescale();
    wr(3'd0, 8'h07); wr(3'd4, 8'h00);
    for (int i = 0; i < 15; i++) pulse();
    chk("R4 no capture before 16th edge", irq_flag, 0);
    pulse();
    chk("R4 capture on 16th edge", irq_flag, 1);
    wr(3'd0, 8'h06); wr(3'd4, 8'h00);
    pulse(); pulse();
    wr(3'd0, 8'h06);
    pulse(); pulse(); pulse();
    chk("R4 ctrl write clears edge count", irq_flag, 0);
    pulse();
    chk("R4 capture on 4th edge", irq_flag, 1);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_compare(input logic [7:0] ctrl, input int pin0, input int pin1,
                           input int stb, input string tag);
    timer_val = 16'h0000;
    wr(3'd1, 8'h34); wr(3'd2, 8'h12); wr(3'd4, 8'h00);
    wr(3'd0, ctrl);
    step(2);
    chk({tag, " pin after mode write"}, pin_out, pin0);
    chk({tag, " no flag before match"}, irq_flag, 0);
    timer_val = 16'h1234;
    step();
    chk({tag, " pin after match"}, pin_out, pin1);
    chk({tag, " flag on match"}, irq_flag, 1);
    chk({tag, " strobes on match"}, {tmr_reset_stb, adc_start_stb}, stb ? 3 : 0);
    timer_val = 16'h1235;
    step();
    chk({tag, " strobes one cycle"}, {tmr_reset_stb, adc_start_stb}, 0);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_disabled();
    wr(3'd0, 8'h08); timer_val = 0; step(2);
    timer_val = 16'h1234; step(2);
    chk("R2 setup pin high", pin_out, 1);
    wr(3'd4, 8'h00);
    wr(3'd0, 8'h00); step();
    chk("R2 disable forces pin low", pin_out, 0);
    timer_val = 0; step(); timer_val = 16'h1234; step(2);
    pulse();
    chk("R2 no flag when disabled", irq_flag, 0);
    wr(3'd0, 8'h02); timer_val = 0; step(); timer_val = 16'h1234; step(2);
    pulse();
    chk("R2 unlisted mode stays off", {pin_out, irq_flag}, 0);
    timer_val = 0;
    wr(3'd0, 8'h3A); step(); timer_val = 16'h1234; step(2);
    chk("R12 bits 5:4 no pin effect", pin_out, 0);
    chk("R7 flag-only match", irq_flag, 1);
    wr(3'd4, 8'h00); wr(3'd0, 8'h00);
  endtask

  task automatic t_pwm(input int duty, input logic [7:0] period, input logic [1:0] low_mode,
                       input string tag);
    int len, hi, cnt, exp;
    len = 4 * (period + 1);
    cnt = 0;
    timer_val = 0;
    wr(3'd3, period);
    wr(3'd1, 8'(duty >> 2));
    wr(3'd0, {2'b00, 2'(duty), 2'b11, low_mode});
    for (int i = 0; i < 3 * len; i++) begin
      timer_val = 16'(cnt); step();
      cnt = (cnt == len - 1) ? 0 : cnt + 1;
    end
    hi = 0;
    for (int i = 0; i < len; i++) begin
      timer_val = 16'(cnt); step();
      cnt = (cnt == len - 1) ? 0 : cnt + 1;
      if (pin_out) hi++;
    end
    exp = (duty < len) ? duty : len;
    chk(tag, hi, exp);
    wr(3'd0, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    step();
    t_reset();
    t_capture_edges();
    t_capture_prescale();
    t_compare(8'h08, 0, 1, 0, "R5 set on match");
    t_compare(8'h09, 1, 0, 0, "R6 clear on match");
    t_compare(8'h0A, 0, 0, 0, "R7 flag only");
    t_compare(8'h0B, 0, 0, 1, "R8 special event");
    t_disabled();
    t_pwm(0,   8'd9, 2'b00, "R11 duty zero high count");
    t_pwm(21,  8'd9, 2'b01, "R10 midpoint duty with fraction");
    t_pwm(40,  8'd9, 2'b10, "R11 duty equal to period");
    t_pwm(100, 8'd9, 2'b11, "R11 duty above period");
    t_pwm(7,   8'd3, 2'b00, "R10 short period duty");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule